// File: doc/BRIEF.md
# Configurable Pad Input Capture Cell

This block is the receive half of a programmable I/O cell. It takes one single-ended pad bit and turns it into a word of `LANES` bits (four by default) for the core. A static parameter selects one of four capture styles. The first passes the pad straight through. The second registers it once per slow clock. The third catches one bit on each edge of the slow clock. The fourth shifts the pad in on both edges of a fast clock that runs at twice the slow rate and releases a parallel word once per slow cycle.

The word is a stream that cannot be stalled, because a pad cannot hold its data back. For that reason the stream has no ready signal. `word_valid` marks every slow-clock update that holds fresh data, and a consumer must take every word that comes with valid high.

A small controller next to the data path keeps a delay-tap count for an external pad-delay element. It samples its controls on the falling edge of the delay clock and steps the count up or down. The count saturates at both ends, and a dedicated input resets it. In the deserializer style, the delay clock must be the slow input clock.

Top module: `io_rx_capture`

## Requirements
- R1: With `MODE = CAP_BYPASS`, lane 0 of `core_word` follows `pad_in` with no register, and all other lanes are 0.
- R2: With `MODE = CAP_SDR`, lane 0 holds the pad value sampled at the most recent rising edge of `in_clk`, and all other lanes are 0.
- R3: With `MODE = CAP_DDR`, after rising edge k of `in_clk` the word holds two samples. Lane 0 is the pad value sampled at rising edge k-1. Lane 1 is the pad value sampled at the falling edge between k-1 and k. Lanes 2 and up are 0.
- R4: With `MODE = CAP_DESER`, `in_fast_clk` runs at twice the rate of `in_clk` with coincident rising edges, and the pad is sampled on both of its edges. Number the fast edges consecutively and let n be the fast edge that coincides with a rising edge of `in_clk`. After that rising edge, lane i holds the sample from fast edge n-2-LANES+i, so lane 0 holds the earliest bit.
- R5: `word_valid` is 0 during reset. In SDR, DDR and deserializer modes it goes to 1 after the 1st, 2nd and 3rd rising edge of `in_clk` following reset release, respectively. In bypass mode it is 1 whenever reset is released. Once high, it stays high until the next reset. Each rising edge of `in_clk` updates the word once.
- R6: An asynchronous active-low `rst_n` clears every registered lane and `word_valid`, and sets `tap_count` to `TAP_INIT`.
- R7: On each falling edge of `dly_clk` with `dly_en` = 1 and `dly_rst` = 0, `tap_count` goes up by one when `dly_inc` = 1 and down by one when `dly_inc` = 0.
- R8: `tap_count` saturates at 0 when stepping down and at 2^TAP_BITS-1 when stepping up. It never wraps.
- R9: `dly_rst` = 1 at a falling edge of `dly_clk` loads `TAP_INIT`, whatever the values of `dly_en` and `dly_inc`.
- R10: With `dly_en` = 0 and `dly_rst` = 0, `tap_count` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Slow core input clock; word rate |
| in_fast_clk | input | 1 | Bit clock at twice `in_clk`, used only by the deserializer |
| dly_clk | input | 1 | Delay-control clock, sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Single-ended pad data |
| dly_en | input | 1 | Enables one tap step |
| dly_inc | input | 1 | Step direction: 1 up, 0 down |
| dly_rst | input | 1 | Reloads the tap count to `TAP_INIT` |
| core_word | output | LANES | Captured word, lane 0 earliest |
| word_valid | output | 1 | Word holds fresh data |
| tap_count | output | TAP_BITS | Delay tap count for the pad-delay element |

## Verification
The bench runs one instance of each mode side by side on a pad pattern whose four-bit groups cover all sixteen values. Expected lanes come from the fast-edge index of each sample. A deserializer that reversed lane order, or that took its bits off by one fast edge, would show up as a rotated or mirrored nibble. A DDR path that swapped its rising and falling samples, or did not realign them to the rising edge, would put the lanes out of place. The bench checks the exact edge at which `word_valid` rises, which exposes a fill count that is off by one and lets stale reset data through as valid. The tap sweep drives the count past both ends, asserts reset together with enable, and toggles direction while disabled. A counter that wrapped, or that gave enable priority over reset, or that moved while disabled, would fail these checks.

// File: rtl/iocap_pkg.sv
package iocap_pkg;

  typedef enum logic [1:0] {
    CAP_BYPASS = 2'd0,
    CAP_SDR    = 2'd1,
    CAP_DDR    = 2'd2,
    CAP_DESER  = 2'd3
  } cap_mode_e;

  // Slow rising edges after reset before the word carries fresh data.
  function automatic int fill_edges(cap_mode_e m);
    case (m)
      CAP_SDR:   return 1;
      CAP_DDR:   return 2;
      CAP_DESER: return 3;
      default:   return 0;
    endcase
  endfunction

  // Lanes that carry data in each style.
  function automatic int used_lanes(cap_mode_e m, int lanes);
    case (m)
      CAP_DDR:   return 2;
      CAP_DESER: return lanes;
      default:   return 1;
    endcase
  endfunction

endpackage

// File: rtl/iocap_tap.sv
module iocap_tap #(
  parameter int TAP_BITS = 6,
  parameter int TAP_INIT = 16
) (
  input  logic                dly_clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic                step_up,
  input  logic                reload,
  output logic [TAP_BITS-1:0] tap
);
  localparam logic [TAP_BITS-1:0] TAP_TOP  = '1;
  localparam logic [TAP_BITS-1:0] TAP_BOOT = TAP_BITS'(TAP_INIT);

  logic [TAP_BITS-1:0] tap_q;

  always_ff @(negedge dly_clk or negedge rst_n) begin
    if (!rst_n)
      tap_q <= TAP_BOOT;
    else if (reload)
      tap_q <= TAP_BOOT;
    else if (step_en) begin
      if (step_up && tap_q != TAP_TOP)
        tap_q <= tap_q + 1'b1;
      else if (!step_up && tap_q != '0)
        tap_q <= tap_q - 1'b1;
    end
  end

  assign tap = tap_q;
endmodule

// File: rtl/iocap_fill.sv
module iocap_fill #(
  parameter int FILL = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic valid
);
  generate
    if (FILL == 0) begin : g_none
      assign valid = rst_n;
    end else begin : g_count
      localparam int CW = $clog2(FILL + 1);
      localparam logic [CW-1:0] FULL = CW'(FILL);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (cnt_q != FULL)
          cnt_q <= cnt_q + 1'b1;
      end
      assign valid = (cnt_q == FULL);
    end
  endgenerate
endmodule

// File: rtl/iocap_ddr.sv
module iocap_ddr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad,
  output logic [1:0] pair
);
  logic rise_q, fall_q;
  logic [1:0] pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= pad;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= pad;
  end

  // Realign both halves of one slow cycle to the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pair_q <= '0;
    else        pair_q <= {fall_q, rise_q};
  end

  assign pair = pair_q;
endmodule

// File: rtl/iocap_deser.sv
module iocap_deser #(
  parameter int LANES = 4
) (
  input  logic             fast_clk,
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             pad,
  output logic [LANES-1:0] word
);
  logic pos_q, neg_q;
  logic [LANES-1:0] hold_q;
  logic [LANES-1:0] word_q;

  always_ff @(posedge fast_clk or negedge rst_n) begin
    if (!rst_n) pos_q <= 1'b0;
    else        pos_q <= pad;
  end

  always_ff @(negedge fast_clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pad;
  end

  // Each fast rising edge pushes one ordered bit pair in at the top,
  // so the oldest bits drift towards lane 0.
  generate
    if (LANES == 2) begin : g_single
      always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= {neg_q, pos_q};
      end
    end else begin : g_shift
      always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= {neg_q, pos_q, hold_q[LANES-1:2]};
      end
    end
  endgenerate

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= hold_q;
  end

  assign word = word_q;
endmodule

// File: rtl/io_rx_capture.sv
module io_rx_capture
  import iocap_pkg::*;
#(
  parameter cap_mode_e MODE     = CAP_DESER,
  parameter int        LANES    = 4,
  parameter int        TAP_BITS = 6,
  parameter int        TAP_INIT = 16
) (
  input  logic                in_clk,
  input  logic                in_fast_clk,
  input  logic                dly_clk,
  input  logic                rst_n,
  input  logic                pad_in,
  input  logic                dly_en,
  input  logic                dly_inc,
  input  logic                dly_rst,
  output logic [LANES-1:0]    core_word,
  output logic                word_valid,
  output logic [TAP_BITS-1:0] tap_count
);
  // LANES must be even and at least 4.
  localparam int FILL = fill_edges(MODE);

  generate
    case (MODE)
      CAP_BYPASS: begin : g_bypass
        assign core_word = {{(LANES-1){1'b0}}, pad_in};
      end
      CAP_SDR: begin : g_sdr
        logic sdr_q;
        always_ff @(posedge in_clk or negedge rst_n) begin
          if (!rst_n) sdr_q <= 1'b0;
          else        sdr_q <= pad_in;
        end
        assign core_word = {{(LANES-1){1'b0}}, sdr_q};
      end
      CAP_DDR: begin : g_ddr
        logic [1:0] pair;
        iocap_ddr u_ddr (
          .clk   (in_clk),
          .rst_n (rst_n),
          .pad   (pad_in),
          .pair  (pair)
        );
        assign core_word = {{(LANES-2){1'b0}}, pair};
      end
      default: begin : g_deser
        iocap_deser #(.LANES(LANES)) u_deser (
          .fast_clk (in_fast_clk),
          .slow_clk (in_clk),
          .rst_n    (rst_n),
          .pad      (pad_in),
          .word     (core_word)
        );
      end
    endcase
  endgenerate

  iocap_fill #(.FILL(FILL)) u_fill (
    .clk   (in_clk),
    .rst_n (rst_n),
    .valid (word_valid)
  );

  iocap_tap #(.TAP_BITS(TAP_BITS), .TAP_INIT(TAP_INIT)) u_tap (
    .dly_clk (dly_clk),
    .rst_n   (rst_n),
    .step_en (dly_en),
    .step_up (dly_inc),
    .reload  (dly_rst),
    .tap     (tap_count)
  );
endmodule

// File: rtl/io_rx_capture_chk.sv
module io_rx_capture_chk
  import iocap_pkg::*;
#(
  parameter cap_mode_e MODE     = CAP_DESER,
  parameter int        LANES    = 4,
  parameter int        TAP_BITS = 6,
  parameter int        TAP_INIT = 16
) (
  input logic                in_clk,
  input logic                dly_clk,
  input logic                rst_n,
  input logic                pad_in,
  input logic                dly_en,
  input logic                dly_inc,
  input logic                dly_rst,
  input logic [LANES-1:0]    core_word,
  input logic                word_valid,
  input logic [TAP_BITS-1:0] tap_count
);
  localparam logic [TAP_BITS-1:0] TOP  = '1;
  localparam logic [TAP_BITS-1:0] BOOT = TAP_BITS'(TAP_INIT);
  localparam int USED = used_lanes(MODE, LANES);

  p_tap_up_r7: assert property (@(negedge dly_clk) disable iff (!rst_n)
    (!dly_rst && dly_en && dly_inc && tap_count != TOP) |=> tap_count == $past(tap_count) + 1'b1);

  p_tap_down_r7: assert property (@(negedge dly_clk) disable iff (!rst_n)
    (!dly_rst && dly_en && !dly_inc && tap_count != '0) |=> tap_count == $past(tap_count) - 1'b1);

  p_tap_top_r8: assert property (@(negedge dly_clk) disable iff (!rst_n)
    (!dly_rst && dly_en && dly_inc && tap_count == TOP) |=> tap_count == TOP);

  p_tap_floor_r8: assert property (@(negedge dly_clk) disable iff (!rst_n)
    (!dly_rst && dly_en && !dly_inc && tap_count == '0) |=> tap_count == '0);

  p_tap_reload_r9: assert property (@(negedge dly_clk) disable iff (!rst_n)
    dly_rst |=> tap_count == BOOT);

  p_tap_idle_r10: assert property (@(negedge dly_clk) disable iff (!rst_n)
    (!dly_rst && !dly_en) |=> $stable(tap_count));

  p_valid_sticky_r5: assert property (@(posedge in_clk) disable iff (!rst_n)
    word_valid |=> word_valid);

  generate
    if (USED < LANES) begin : g_zero
      p_spare_zero_r1: assert property (@(posedge in_clk) disable iff (!rst_n)
        core_word[LANES-1:USED] == '0);
    end
    if (MODE == CAP_SDR) begin : g_sdr
      p_sdr_lane0_r2: assert property (@(posedge in_clk) disable iff (!rst_n)
        word_valid |-> core_word[0] == $past(pad_in));
    end else if (MODE == CAP_DDR) begin : g_ddr
      p_ddr_lane0_r3: assert property (@(posedge in_clk) disable iff (!rst_n)
        word_valid |-> core_word[0] == $past(pad_in, 2));
    end else if (MODE == CAP_DESER) begin : g_des
      p_deser_order_r4: assert property (@(posedge in_clk) disable iff (!rst_n)
        word_valid |-> core_word[LANES-2] == $past(pad_in, 2));
    end else begin : g_byp
      always_comb begin
        if (rst_n) p_bypass_r1: assert (core_word[0] == pad_in);
      end
    end
  endgenerate
endmodule

bind io_rx_capture io_rx_capture_chk #(
  .MODE(MODE), .LANES(LANES), .TAP_BITS(TAP_BITS), .TAP_INIT(TAP_INIT)
) u_chk (
  .in_clk     (in_clk),
  .dly_clk    (dly_clk),
  .rst_n      (rst_n),
  .pad_in     (pad_in),
  .dly_en     (dly_en),
  .dly_inc    (dly_inc),
  .dly_rst    (dly_rst),
  .core_word  (core_word),
  .word_valid (word_valid),
  .tap_count  (tap_count)
);

// File: tb/tb_io_rx_capture.sv
`timescale 1ns/1ps
module tb_io_rx_capture;
  import iocap_pkg::*;

  localparam int LANES = 4;
  localparam int TB    = 6;
  localparam int TI    = 16;
  localparam int TMAX  = 63;

  logic sclk = 1'b0;   // 250 MHz, rising at 2 + 4k ns
  logic fclk = 1'b1;   // 500 MHz, one edge every ns
  logic rst_n = 1'b0, pad = 1'b0, den = 1'b0, dinc = 1'b0, drst = 1'b0;

  logic [LANES-1:0] w_byp, w_sdr, w_ddr, w_des;
  logic v_byp, v_sdr, v_ddr, v_des;
  logic [TB-1:0] t_byp, t_sdr, t_ddr, t_des;

  int checks = 0;
  int fails  = 0;

  always #2 sclk = ~sclk;
  always #1 fclk = ~fclk;

  io_rx_capture #(.MODE(CAP_BYPASS), .LANES(LANES), .TAP_BITS(TB), .TAP_INIT(TI)) u_byp (
    .in_clk(sclk), .in_fast_clk(fclk), .dly_clk(sclk), .rst_n(rst_n), .pad_in(pad),
    .dly_en(den), .dly_inc(dinc), .dly_rst(drst),
    .core_word(w_byp), .word_valid(v_byp), .tap_count(t_byp));
  io_rx_capture #(.MODE(CAP_SDR), .LANES(LANES), .TAP_BITS(TB), .TAP_INIT(TI)) u_sdr (
    .in_clk(sclk), .in_fast_clk(fclk), .dly_clk(sclk), .rst_n(rst_n), .pad_in(pad),
    .dly_en(den), .dly_inc(dinc), .dly_rst(drst),
    .core_word(w_sdr), .word_valid(v_sdr), .tap_count(t_sdr));
  io_rx_capture #(.MODE(CAP_DDR), .LANES(LANES), .TAP_BITS(TB), .TAP_INIT(TI)) u_ddr (
    .in_clk(sclk), .in_fast_clk(fclk), .dly_clk(sclk), .rst_n(rst_n), .pad_in(pad),
    .dly_en(den), .dly_inc(dinc), .dly_rst(drst),
    .core_word(w_ddr), .word_valid(v_ddr), .tap_count(t_ddr));
  io_rx_capture #(.MODE(CAP_DESER), .LANES(LANES), .TAP_BITS(TB), .TAP_INIT(TI)) dut (
    .in_clk(sclk), .in_fast_clk(fclk), .dly_clk(sclk), .rst_n(rst_n), .pad_in(pad),
    .dly_en(den), .dly_inc(dinc), .dly_rst(drst),
    .core_word(w_des), .word_valid(v_des), .tap_count(t_des));

  // Pad bit at fast edge j; four-bit groups walk through all 16 values.
  function automatic logic patt(int j);
    int nib;
    nib = (((j >> 2) * 5) + 3 + (j >> 6)) % 16;
    return logic'((nib >> (j & 3)) & 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Sample edge j is set half a ns before it.
  initial begin
    #0.5;
    for (int j = 1; j < 1000000; j++) begin
      pad = patt(j);
      #1;
    end
  end

  task automatic data_sweep();
    int n;
    for (int c = 1; c <= 90; c++) begin
      @(posedge sclk);
      #0.25;
      n = 4 * c + 18;
      chk("R5 bypass valid", 32'(v_byp), 32'd1);
      chk("R5 sdr valid",    32'(v_sdr), 32'(c >= 1));
      chk("R5 ddr valid",    32'(v_ddr), 32'(c >= 2));
      chk("R5 deser valid",  32'(v_des), 32'(c >= 3));
      chk("R1 bypass word", 32'(w_byp), {31'd0, patt(n)});
      chk("R2 sdr word",    32'(w_sdr), {31'd0, patt(n)});
      if (c >= 2)
        chk("R3 ddr word", 32'(w_ddr), {30'd0, patt(n - 2), patt(n - 4)});
      if (c >= 3)
        chk("R4 deser word", 32'(w_des),
            {28'd0, patt(n - 3), patt(n - 4), patt(n - 5), patt(n - 6)});
    end
  endtask

  int model = TI;

  task automatic tap_step(logic en, logic inc, logic rl);
    string tag;
    den = en; dinc = inc; drst = rl;
    if (rl)                           tag = "R9 reload";
    else if (!en)                     tag = "R10 hold";
    else if (inc && model == TMAX)    tag = "R8 top";
    else if (!inc && model == 0)      tag = "R8 floor";
    else                              tag = "R7 step";
    @(posedge sclk);
    #0.25;
    if (rl)       model = TI;
    else if (en)  model = inc ? ((model == TMAX) ? TMAX : model + 1)
                              : ((model == 0) ? 0 : model - 1);
    chk(tag, 32'(t_des), 32'(model));
  endtask

  task automatic tap_sweep();
    @(posedge sclk);
    #0.25;
    for (int i = 0; i < 52; i++) tap_step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++)  tap_step(1'b0, i[0], 1'b0);
    tap_step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 24; i++) tap_step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++)  tap_step(1'b0, 1'b0, 1'b0);
    tap_step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) tap_step(i % 5 != 4, i % 3 != 0, i == 25);
    den = 1'b0; dinc = 1'b0; drst = 1'b0;
  endtask

  initial begin
    #10;
    chk("R6 sdr word in reset",   32'(w_sdr), 32'd0);
    chk("R6 ddr word in reset",   32'(w_ddr), 32'd0);
    chk("R6 deser word in reset", 32'(w_des), 32'd0);
    chk("R6 valid in reset", 32'({v_byp, v_sdr, v_ddr, v_des}), 32'd0);
    chk("R6 tap in reset",   32'(t_des), 32'(TI));
    chk("R6 tap in reset sdr", 32'(t_sdr), 32'(TI));
    #11;
    rst_n = 1'b1;
    fork
      data_sweep();
      tap_sweep();
    join
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule